// File: doc/BRIEF.md
# Bus Master Security Filter

This block sits on the path from a single bus master to the downstream memory system. For each request it looks at a security attribution for the target address, which an external lookup unit supplies on the same cycle. It then combines that attribution with the master's configured security state and decides what happens to the request. The request can go downstream marked secure, go downstream marked non-secure, or be stopped at the filter.

A stopped request never reaches the downstream port. The filter answers it by itself on the next cycle. Depending on a configuration input, a stopped request completes quietly or returns an error. A quiet completion reads as zero, drops its write data and gives an OKAY response. Each error block also sets a sticky interrupt flag, which a clear input resets. Requests that go downstream keep their address, size code, write data and byte order unchanged, and the downstream response is handed back to the master unchanged as well.

Top module: `sec_filter`

## Requirements
- R1: With attribution code 0 (exempt), the request is forwarded, and `dn_nonsec` equals `master_ns`.
- R2: With attribution code 1 (non-secure), the request is forwarded with `dn_nonsec` high, whatever `master_ns` and `err_mode` are.
- R3: With attribution code 2 (secure) or code 3 (invalid, which is handled as secure) and `master_ns` low, the request is forwarded with `dn_nonsec` low.
- R4: With a code of 2 or 3 and `master_ns` high, the request is accepted (`up_ready` high) but does not assert `dn_valid`. The next cycle carries `up_rsp_valid` with all-zero read data and `up_rsp_err` low when `err_mode` was low.
- R5: For such a blocked request with `err_mode` high, the response on the next cycle has `up_rsp_err` high and zero read data.
- R6: An error block accepted while `irq_clr` is low sets `irq` on the next cycle. `irq` then stays high until it is cleared.
- R7: While `irq_clr` is high, `irq` is low from the following cycle on, and an error block accepted during that time does not set it.
- R8: After reset, `irq` and `up_rsp_valid` are low, and `dn_valid` stays low until a request arrives.
- R9: A forwarded request presents address, write flag, size code (0=1 byte, 1=2, 2=4, 3=8) and write data unchanged downstream. The downstream read data and error flag are returned unchanged.
- R10: Only one request is outstanding at a time. After a downstream handshake, `up_ready` stays low until the downstream response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| master_ns | input | 1 | Master configured as non-secure |
| err_mode | input | 1 | Blocked requests return an error when high |
| irq_clr | input | 1 | Clears and holds clear the interrupt flag |
| irq | output | 1 | Sticky error-block interrupt |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted |
| up_write | input | 1 | Request is a write |
| up_addr | input | AW | Request address |
| up_size | input | 2 | Access size code |
| up_wdata | input | DW | Write data, little-endian |
| up_rsp_valid | output | 1 | Response to master valid |
| up_rsp_err | output | 1 | Response carries an error |
| up_rsp_rdata | output | DW | Read data to master |
| attr_addr | output | AW | Address sent to the attribution lookup |
| attr_code | input | 2 | Attribution: 0 exempt, 1 non-secure, 2 secure, 3 invalid |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request accepted |
| dn_write | output | 1 | Downstream write flag |
| dn_nonsec | output | 1 | Downstream request marked non-secure |
| dn_addr | output | AW | Downstream address |
| dn_size | output | 2 | Downstream size code |
| dn_wdata | output | DW | Downstream write data |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_err | input | 1 | Downstream response error |
| dn_rsp_rdata | input | DW | Downstream read data |

## Verification
The assertions assume three things about the inputs. First, `attr_code` is valid for `up_addr` in the same cycle the request is offered. Second, the configuration inputs are stable while a request is offered. Third, the downstream port returns exactly one response per handshake, and only after that handshake. The stimulus follows these rules. It drives the request fields and the attribution together on a falling edge. It changes configuration only between requests. It raises `dn_rsp_valid` for a single cycle, and only once a downstream handshake has completed.

// File: rtl/sec_filter.sv
module sec_filter #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_ns,
  input  logic          err_mode,
  input  logic          irq_clr,
  output logic          irq,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic          up_write,
  input  logic [AW-1:0] up_addr,
  input  logic [1:0]    up_size,
  input  logic [DW-1:0] up_wdata,
  output logic          up_rsp_valid,
  output logic          up_rsp_err,
  output logic [DW-1:0] up_rsp_rdata,
  output logic [AW-1:0] attr_addr,
  input  logic [1:0]    attr_code,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic          dn_write,
  output logic          dn_nonsec,
  output logic [AW-1:0] dn_addr,
  output logic [1:0]    dn_size,
  output logic [DW-1:0] dn_wdata,
  input  logic          dn_rsp_valid,
  input  logic          dn_rsp_err,
  input  logic [DW-1:0] dn_rsp_rdata
);

  localparam logic [1:0] ATTR_EXEMPT = 2'd0;
  localparam logic [1:0] ATTR_NS     = 2'd1;

  typedef enum logic {S_IDLE, S_FWD} st_t;

  st_t  st;
  logic blk_rsp_q, blk_err_q, irq_q;

  logic sec_region, blocked, idle, accept_blk;

  assign sec_region = (attr_code != ATTR_EXEMPT) && (attr_code != ATTR_NS);
  assign blocked    = sec_region && master_ns;
  assign idle       = (st == S_IDLE) && !blk_rsp_q;
  assign accept_blk = idle && up_valid && blocked;

  assign attr_addr = up_addr;

  assign dn_valid  = idle && up_valid && !blocked;
  assign dn_nonsec = (attr_code == ATTR_NS) || master_ns;
  assign dn_write  = up_write;
  assign dn_addr   = up_addr;
  assign dn_size   = up_size;
  assign dn_wdata  = up_wdata;

  assign up_ready = idle && (blocked || dn_ready);

  assign up_rsp_valid = blk_rsp_q || ((st == S_FWD) && dn_rsp_valid);
  assign up_rsp_err   = blk_rsp_q ? blk_err_q : dn_rsp_err;
  assign up_rsp_rdata = blk_rsp_q ? '0 : dn_rsp_rdata;

  assign irq = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      blk_rsp_q <= 1'b0;
      blk_err_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (dn_valid && dn_ready)
        st <= S_FWD;
      else if ((st == S_FWD) && dn_rsp_valid)
        st <= S_IDLE;
      blk_rsp_q <= accept_blk;
      blk_err_q <= accept_blk && err_mode;
      if (irq_clr)
        irq_q <= 1'b0;
      else if (accept_blk && err_mode)
        irq_q <= 1'b1;
    end
  end

endmodule

module sec_filter_chk #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          master_ns,
  input logic          err_mode,
  input logic          irq_clr,
  input logic          irq,
  input logic          up_valid,
  input logic          up_ready,
  input logic          up_rsp_valid,
  input logic          up_rsp_err,
  input logic [DW-1:0] up_rsp_rdata,
  input logic [1:0]    attr_code,
  input logic          dn_valid,
  input logic          dn_ready,
  input logic          dn_nonsec
);

  logic blk_hs;
  assign blk_hs = up_valid && up_ready && attr_code[1] && master_ns;

  assert_exempt_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && attr_code == 2'd0) |-> (dn_nonsec == master_ns));

  assert_ns_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && attr_code == 2'd1) |-> dn_nonsec);

  assert_sec_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && attr_code[1]) |-> (!dn_nonsec && !master_ns));

  assert_no_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    blk_hs |-> !dn_valid);

  assert_blk_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_hs |=> (up_rsp_valid && up_rsp_rdata == '0 && up_rsp_err == $past(err_mode)));

  assert_irq_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_hs && err_mode && !irq_clr) |=> irq);

  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  assert_irq_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> !irq);

  assert_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_ready) |=> !up_ready);

endmodule

bind sec_filter sec_filter_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .master_ns(master_ns), .err_mode(err_mode),
  .irq_clr(irq_clr), .irq(irq), .up_valid(up_valid), .up_ready(up_ready),
  .up_rsp_valid(up_rsp_valid), .up_rsp_err(up_rsp_err),
  .up_rsp_rdata(up_rsp_rdata), .attr_code(attr_code), .dn_valid(dn_valid),
  .dn_ready(dn_ready), .dn_nonsec(dn_nonsec)
);

// File: tb/sim_sec_filter.sv
module sim_sec_filter;
  localparam int AW = 32;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_ns = 0, err_mode = 0, irq_clr = 0;
  logic irq;
  logic up_valid = 0, up_write = 0;
  logic up_ready;
  logic [AW-1:0] up_addr = '0;
  logic [1:0] up_size = '0;
  logic [DW-1:0] up_wdata = '0;
  logic up_rsp_valid, up_rsp_err;
  logic [DW-1:0] up_rsp_rdata;
  logic [AW-1:0] attr_addr;
  logic [1:0] attr_code = '0;
  logic dn_valid, dn_write, dn_nonsec;
  logic dn_ready = 1'b1;
  logic [AW-1:0] dn_addr;
  logic [1:0] dn_size;
  logic [DW-1:0] dn_wdata;
  logic dn_rsp_valid = 0, dn_rsp_err = 0;
  logic [DW-1:0] dn_rsp_rdata = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sec_filter #(.AW(AW), .DW(DW)) u0 (.*);

  // {attr[1:0], master_ns, err_mode, write, exp_fwd, exp_ns, exp_err}
  localparam int NV = 12;
  localparam logic [7:0] VEC [0:NV-1] = '{
    8'b00_0_0_0_1_0_0, 8'b00_1_1_1_1_1_0, 8'b01_0_0_0_1_1_0,
    8'b01_1_1_1_1_1_0, 8'b10_0_1_0_1_0_0, 8'b10_1_0_0_0_0_0,
    8'b10_1_0_1_0_0_0, 8'b10_1_1_0_0_0_1, 8'b11_0_0_1_1_0_0,
    8'b11_1_1_1_0_0_1, 8'b11_1_0_0_0_0_0, 8'b00_1_0_0_1_1_0};

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic error_block();
    @(negedge clk);
    attr_code = 2'd2; master_ns = 1; err_mode = 1; up_valid = 1;
    @(negedge clk);
    up_valid = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %h expected %h", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(irq == 0, "R8 irq after reset", irq, 0);
    chk(up_rsp_valid == 0, "R8 rsp after reset", up_rsp_valid, 0);
    chk(dn_valid == 0, "R8 dn_valid idle", dn_valid, 0);

    for (int i = 0; i < NV; i++) begin
      automatic logic [7:0] v = VEC[i];
      automatic logic [DW-1:0] wd = 64'hA5A5_0000_0000_0000 | 64'(i);
      @(negedge clk);
      attr_code = v[7:6]; master_ns = v[5]; err_mode = v[4]; up_write = v[3];
      up_addr = 32'h1000 + 32'(i * 8); up_size = 2'(i); up_wdata = wd; up_valid = 1;
      #1;
      chk(up_ready == 1, "R10 ready when idle", up_ready, 1);
      if (v[2]) begin
        chk(dn_valid == 1, "R1/R2/R3 forwarded", dn_valid, 1);
        chk(dn_nonsec == v[1], "R1/R2/R3 nonsec mark", dn_nonsec, v[1]);
        chk(dn_addr == up_addr && dn_size == 2'(i) && dn_wdata == wd && dn_write == v[3],
            "R9 request fields", {dn_addr, 30'd0, dn_size}, {up_addr, 30'd0, 2'(i)});
        @(negedge clk);
        up_valid = 0; dn_rsp_valid = 1; dn_rsp_rdata = ~wd; dn_rsp_err = i[0];
        #1;
        chk(up_ready == 0, "R10 ready low while waiting", up_ready, 0);
        chk(up_rsp_valid == 1 && up_rsp_rdata == ~wd && up_rsp_err == i[0],
            "R9 response passthrough", up_rsp_rdata, ~wd);
        @(negedge clk);
        dn_rsp_valid = 0;
      end else begin
        chk(dn_valid == 0, "R4 blocked not forwarded", dn_valid, 0);
        @(negedge clk);
        up_valid = 0;
        #1;
        chk(up_rsp_valid == 1 && up_rsp_rdata == '0, "R4 local zero response", up_rsp_rdata, 0);
        chk(up_rsp_err == v[0], v[0] ? "R5 error response" : "R4 okay response", up_rsp_err, v[0]);
      end
    end

    repeat (3) @(negedge clk); #1;
    chk(irq == 1, "R6 irq set and sticky", irq, 1);

    @(negedge clk); irq_clr = 1;
    @(negedge clk); #1;
    chk(irq == 0, "R7 irq cleared", irq, 0);
    error_block(); #1;
    chk(irq == 0, "R7 block under clear", irq, 0);
    @(negedge clk); irq_clr = 0;
    @(negedge clk); #1;
    chk(irq == 0, "R7 stays clear", irq, 0);
    error_block(); #1;
    chk(irq == 1, "R6 irq set by error block", irq, 1);

    // quiet block must not set irq
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    @(negedge clk);
    attr_code = 2'd3; master_ns = 1; err_mode = 0; up_valid = 1;
    @(negedge clk); up_valid = 0;
    @(negedge clk); #1;
    chk(irq == 0, "R6 quiet block leaves irq", irq, 0);

    // stall: downstream not ready, then a long wait for the response
    @(negedge clk);
    attr_code = 2'd1; master_ns = 0; dn_ready = 0; up_valid = 1; up_addr = 32'h2000;
    #1;
    chk(dn_valid == 1 && up_ready == 0, "R10 stall holds request", {dn_valid, up_ready}, 2'b10);
    @(negedge clk); dn_ready = 1;
    @(negedge clk); up_valid = 1; up_addr = 32'h3000;
    #1;
    chk(dn_valid == 0 && up_ready == 0, "R10 second request held off", {dn_valid, up_ready}, 2'b00);
    @(negedge clk); dn_rsp_valid = 1; dn_rsp_rdata = 64'h1234; up_valid = 0;
    #1;
    chk(up_rsp_valid == 1 && up_rsp_rdata == 64'h1234, "R9 delayed response", up_rsp_rdata, 64'h1234);
    @(negedge clk); dn_rsp_valid = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule